// File: doc/BRIEF.md
# SPI Status Byte Serializer

This block keeps a small table of status bytes and sends the whole table out as a serial bit stream while an external SPI master clocks it. A one-cycle arm pulse prepares a transfer. The block then waits for the master to pull the active-low chip select down. After that, each rising edge of the external SPI clock uses up the bit currently on the data line, and the next bit takes its place.

The SPI clock and the chip select arrive from outside with no relation to the system clock. Each of them passes through a two-flop synchronizer before any state decision uses it. A rising edge on the synchronized SPI clock is turned into a pulse that lasts one system cycle, so the transfer advances by one bit per SPI clock whatever the high time of that clock. The transfer starts at the highest table entry and works down to entry 0, and each byte goes out most significant bit first. If the master releases chip select before the transfer ends, the block drops back to idle, and the next transfer starts again from the beginning.

Top module: `spi_stat_serializer`

## Requirements
- R1: After a synchronous active-low reset, `busy_o` is 0 and `sdo_o` is 0.
- R2: An arm pulse while idle sets `busy_o` to 1 in the following cycle.
- R3: While the synchronized chip select is high, the block waits and ignores SPI clock edges. The first bit driven after chip select goes low is entry 17, bit 7.
- R4: `sdo_o` is 0 whenever the block is not presenting a data bit. This covers idle, waiting, and the one-cycle advance step that follows each SPI clock rise.
- R5: The stream is 144 bits long. It runs from entry 17 down to entry 0, and each entry is sent with bit 7 first and bit 0 last.
- R6: Table contents are as follows. Entry 0 is {4'b0000, `grp_i`}. Entry 1 is `loop_i`. Entries 2 to 13 are 8'h01. Entries 14 and 15 are 8'hFF. Entries 16 and 17 are 8'h00.
- R7: Exactly one bit is consumed for each rising edge of `sclk_i`, however long `sclk_i` stays high.
- R8: The rising edge that consumes entry 0, bit 0 returns the block to idle, and `busy_o` goes to 0.
- R9: If chip select rises in the middle of a transfer, the block aborts to idle. The next transfer restarts from entry 17, bit 7.
- R10: An arm pulse that arrives while a transfer is in progress has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_i | input | 1 | One-cycle command that arms a transfer |
| sclk_i | input | 1 | Raw SPI clock from the master |
| cs_n_i | input | 1 | Raw chip select from the master, active low |
| grp_i | input | 4 | Group status carried in entry 0 |
| loop_i | input | 8 | Loopback status carried in entry 1 |
| sdo_o | output | 1 | Serial data bit |
| busy_o | output | 1 | High from arm until the transfer ends or aborts |

## Verification
The checker watches the controller on every cycle. It checks that an arm pulse from idle starts a transfer and that waiting persists while chip select is high. It checks that the bit and entry indices hold still in the drive state when no SPI clock edge arrives. It also checks that the final edge and a chip-select release both lead to idle, and that both indices are reloaded in idle. Only the bench scenarios can show that the whole 144-bit stream comes out in the right order with the right contents. They also show that a long SPI clock high time consumes only one bit, that edges seen before chip select falls are ignored, and that a stray arm pulse mid-transfer leaves the stream intact.

// File: rtl/spi_stat_pkg.sv
// Shared types for the SPI status serializer.
// Assumes: controller states fit in three bits; unused codes exist and recover to idle.
package spi_stat_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT     = 3'd1,
        ST_DRIVE    = 3'd2,
        ST_ADV_BIT  = 3'd3,
        ST_ADV_BYTE = 3'd4
    } stat_state_e;
endpackage

// File: rtl/stat_sync2.sv
// Two-flop synchronizer for W independent single-bit signals.
// Assumes: each bit is individually asynchronous; no multi-bit coherence needed.
module stat_sync2 #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Purpose: move raw inputs through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/stat_rise_det.sv
// Rising-edge detector producing a one-cycle pulse.
// Assumes: input already synchronous to clk.
module stat_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    // Purpose: remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    // Purpose: flag a low-to-high change.
    always_comb rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/stat_down_counter.sv
// Loadable down counter with end-of-count flag.
// Assumes: load has priority over decrement; reset value equals the load value.
module stat_down_counter #(
    parameter int           W        = 3,
    parameter logic [W-1:0] LOAD_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         dec_i,
    output logic [W-1:0] val_o,
    output logic         at_end_o
);
    // Purpose: hold, reload or decrement the index.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_o <= LOAD_VAL;
        else if (load_i) val_o <= LOAD_VAL;
        else if (dec_i)  val_o <= val_o - W'(1);
    end

    // Purpose: flag the last index.
    always_comb at_end_o = (val_o == '0);
endmodule

// File: rtl/spi_stat_ctrl.sv
// Transfer controller: idle, wait for chip select, drive, advance bit, advance byte.
// Assumes: cs_s and sclk_rise are synchronous to clk; sclk_rise lasts one cycle.
module spi_stat_ctrl
    import spi_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm_i,
    input  logic        cs_s_i,
    input  logic        sclk_rise_i,
    input  logic        bit_end_i,
    input  logic        byte_end_i,
    output stat_state_e state_o,
    output logic        bit_load_o,
    output logic        bit_dec_o,
    output logic        byte_load_o,
    output logic        byte_dec_o
);
    stat_state_e nxt;

    // Purpose: register the controller state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= nxt;
    end

    // Purpose: choose the next state from synchronized inputs only.
    always_comb begin
        nxt = ST_IDLE;
        case (state_o)
            ST_IDLE:     nxt = arm_i ? ST_WAIT : ST_IDLE;
            ST_WAIT:     nxt = cs_s_i ? ST_WAIT : ST_DRIVE;
            ST_DRIVE: begin
                if (cs_s_i)
                    nxt = ST_IDLE;
                else if (sclk_rise_i && bit_end_i && byte_end_i)
                    nxt = ST_IDLE;
                else if (sclk_rise_i && bit_end_i)
                    nxt = ST_ADV_BYTE;
                else if (sclk_rise_i)
                    nxt = ST_ADV_BIT;
                else
                    nxt = ST_DRIVE;
            end
            ST_ADV_BIT:  nxt = ST_DRIVE;
            ST_ADV_BYTE: nxt = ST_DRIVE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Purpose: derive counter controls from the current state.
    always_comb begin
        bit_load_o  = (state_o == ST_IDLE) || (state_o == ST_WAIT) || (state_o == ST_ADV_BYTE);
        byte_load_o = (state_o == ST_IDLE) || (state_o == ST_WAIT);
        bit_dec_o   = (state_o == ST_ADV_BIT);
        byte_dec_o  = (state_o == ST_ADV_BYTE);
    end
endmodule

// File: rtl/spi_stat_serializer.sv
// Top: serializes a status table onto sdo_o, one bit per synchronized SPI clock rise.
// Assumes: sclk_i and cs_n_i are asynchronous; the master samples sdo_o later
// than four system cycles after each SPI clock rise.
module spi_stat_serializer
    import spi_stat_pkg::*;
#(
    parameter int NUM_BYTES  = 18,
    parameter int BYTE_W     = 8,
    parameter int GRP_W      = 4,
    parameter int ONES_FROM  = 14,
    parameter int ZEROS_FROM = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic [GRP_W-1:0]  grp_i,
    input  logic [BYTE_W-1:0] loop_i,
    output logic              sdo_o,
    output logic              busy_o
);
    localparam int IDX_W = $clog2(NUM_BYTES);
    localparam int BIT_W = $clog2(BYTE_W);

    logic              sclk_s, cs_s, sclk_rise;
    logic              bit_load, bit_dec, byte_load, byte_dec;
    logic              bit_end, byte_end;
    logic [BIT_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  byte_idx;
    logic [BYTE_W-1:0] tab [NUM_BYTES];
    logic [BYTE_W-1:0] sel_byte;
    stat_state_e       state_q;

    stat_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, sclk_i}),
        .q_o   ({cs_s, sclk_s})
    );

    stat_rise_det u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sclk_s),
        .rise_o (sclk_rise)
    );

    stat_down_counter #(.W(BIT_W), .LOAD_VAL(BIT_W'(BYTE_W - 1))) u_bit_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (bit_load),
        .dec_i    (bit_dec),
        .val_o    (bit_idx),
        .at_end_o (bit_end)
    );

    stat_down_counter #(.W(IDX_W), .LOAD_VAL(IDX_W'(NUM_BYTES - 1))) u_byte_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (byte_load),
        .dec_i    (byte_dec),
        .val_o    (byte_idx),
        .at_end_o (byte_end)
    );

    spi_stat_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm_i),
        .cs_s_i      (cs_s),
        .sclk_rise_i (sclk_rise),
        .bit_end_i   (bit_end),
        .byte_end_i  (byte_end),
        .state_o     (state_q),
        .bit_load_o  (bit_load),
        .bit_dec_o   (bit_dec),
        .byte_load_o (byte_load),
        .byte_dec_o  (byte_dec)
    );

    // Table construction: live status in entries 0 and 1, constants elsewhere.
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_tab
        if (g == 0) begin : g_grp
            assign tab[g] = {{(BYTE_W - GRP_W){1'b0}}, grp_i};
        end else if (g == 1) begin : g_loop
            assign tab[g] = loop_i;
        end else if (g < ONES_FROM) begin : g_one
            assign tab[g] = BYTE_W'(1);
        end else if (g < ZEROS_FROM) begin : g_ff
            assign tab[g] = '1;
        end else begin : g_zero
            assign tab[g] = '0;
        end
    end

    // Purpose: select the entry addressed by the byte index.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (byte_idx == IDX_W'(i)) sel_byte = tab[i];
        end
    end

    // Purpose: drive data only in the drive state; flag activity.
    always_comb begin
        sdo_o  = (state_q == ST_DRIVE) ? sel_byte[bit_idx] : 1'b0;
        busy_o = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/spi_stat_checker.sv
// Cycle-level checks on the serializer controller, bound into the top.
module spi_stat_checker
    import spi_stat_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int BIT_W = 3,
    parameter int NUM_BYTES = 18,
    parameter int BYTE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             busy_o,
    input logic             sdo_o,
    input stat_state_e      state_q,
    input logic             cs_s,
    input logic             sclk_rise,
    input logic [BIT_W-1:0] bit_idx,
    input logic [IDX_W-1:0] byte_idx
);
    AST_ARM_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && arm_i) |=> busy_o); // R2

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && cs_s) |=> (state_q == ST_WAIT)); // R3

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o) |-> !sdo_o); // R4

    AST_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (bit_idx == BIT_W'(BYTE_W - 1) && byte_idx == IDX_W'(NUM_BYTES - 1))); // R5

    AST_NO_EDGE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && !sclk_rise) |=> ($stable(bit_idx) && $stable(byte_idx))); // R7

    AST_LAST_BIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && !cs_s && sclk_rise && bit_idx == '0 && byte_idx == '0) |=> !busy_o); // R8

    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && cs_s) |=> (state_q == ST_IDLE)); // R9
endmodule

bind spi_stat_serializer spi_stat_checker #(
    .IDX_W(IDX_W), .BIT_W(BIT_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .busy_o    (busy_o),
    .sdo_o     (sdo_o),
    .state_q   (state_q),
    .cs_s      (cs_s),
    .sclk_rise (sclk_rise),
    .bit_idx   (bit_idx),
    .byte_idx  (byte_idx)
);

// File: tb/spi_stat_serializer_bench.sv
module spi_stat_serializer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] grp = 4'h0;
    logic [7:0] loopv = 8'h00;
    logic       sdo, busy;
    int         n_chk = 0;
    int         n_fail = 0;
    int         cyc = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    spi_stat_serializer u_spi_stat_serializer (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .sclk_i(sclk), .cs_n_i(cs_n),
        .grp_i(grp), .loop_i(loopv), .sdo_o(sdo), .busy_o(busy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected table entry, from R6.
    function automatic logic [7:0] entry(input int idx);
        if (idx == 0)      return {4'h0, grp};
        else if (idx == 1) return loopv;
        else if (idx < 14) return 8'h01;
        else if (idx < 16) return 8'hFF;
        else               return 8'h00;
    endfunction

    // Expected k-th bit of the stream, from R5.
    function automatic logic exp_bit(input int k);
        logic [7:0] b;
        b = entry(17 - k / 8);
        return b[7 - (k % 8)];
    endfunction

    task automatic arm_pulse();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    // One SPI clock; gap sample checks the advance step drives 0 (R4).
    task automatic sclk_pulse(input int hold);
        sclk = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 gap", {7'd0, sdo}, 8'h00);
        repeat (hold) @(negedge clk);
        sclk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Full transfer; optional long-high pulse and stray arm mid-stream.
    task automatic t_full_transfer(input string tag, input int long_at, input int arm_at);
        arm_pulse();
        check("R2 busy after arm", {7'd0, busy}, 8'h01);
        repeat (3) sclk_pulse(1);            // R3: edges while cs high ignored
        check("R4 waiting", {7'd0, sdo}, 8'h00);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 144; k++) begin
            check({tag, " R5 R6 stream"}, {7'd0, sdo}, {7'd0, exp_bit(k)});
            if (k == arm_at) begin
                arm = 1'b1; @(negedge clk); arm = 1'b0; // R10
            end
            if (k < 143) check("R8 busy mid", {7'd0, busy}, 8'h01);
            sclk_pulse((k == long_at) ? 20 : 1);  // R7 when long
        end
        check("R8 idle at end", {7'd0, busy}, 8'h00);
        check("R4 idle sdo", {7'd0, sdo}, 8'h00);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 busy", {7'd0, busy}, 8'h00);
        check("R1 sdo", {7'd0, sdo}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_abort();
        arm_pulse();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 20; k++) sclk_pulse(1);
        check("R9 busy before abort", {7'd0, busy}, 8'h01);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 aborted", {7'd0, busy}, 8'h00);
        check("R9 sdo quiet", {7'd0, sdo}, 8'h00);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        grp = 4'hA; loopv = 8'h5C;
        t_full_transfer("R5 run1", 60, 70);
        t_abort();
        grp = 4'h3; loopv = 8'hA7;
        t_full_transfer("R9 restart", 130, 5);
        grp = 4'hF; loopv = 8'h81;
        t_full_transfer("R6 run3", 0, -1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule